// File: doc/BRIEF.md
# Two-Backplane Multiplexed Segment LCD Driver

This block drives a segmented liquid-crystal glass built with two common backplanes that share a set of segment lines. It has three binary common-drive pins. An external resistor divider, which is not part of this block, turns those pins into the three-level backplane voltages. The block walks through a four-phase frame, advancing one phase on each periodic tick (10 ms in the target system, giving a 100 Hz plane rate). Each segment line carries plane-1 data, then plane-2 data, then the inverse of plane-1 data, then the inverse of plane-2 data. Every segment therefore sees zero average voltage across a frame.

Display data for the two planes enters through a strobe into holding storage. It is copied into the active registers only when the sequence wraps back to the first phase, so a frame never mixes true and inverted copies of different data. A one-cycle done pulse reports the copy. The common image for the next phase is formed by XOR with a flip mask that alternates between two values. That value and the matching segment word are both ready before the tick, and both land on output registers at the same clock edge. When the enable input is low, every output is held low, which puts no voltage across the glass. The sequence is also re-armed, so the first tick after enabling drives the first phase.

Top module: `lcd2bp_drv`

## Requirements
- R1: While rst_ni is low, com_o, seg_o and done_o are all zero.
- R2: A clock edge with en_i low drives com_o and seg_o to zero. Ticks arriving while en_i is low leave them at zero.
- R3: The first tick sampled with en_i high after reset or after a disable drives phase 0, com_o = 3'b001.
- R4: com_o holds the top pin in bit 2, the middle pin in bit 1 and the low pin in bit 0. It steps through 3'b001, 3'b010, 3'b110, 3'b101 (phases 0 to 3) and back to 3'b001, one step per enabled tick. No other non-zero value ever appears.
- R5: seg_o shows the active plane-1 word in phase 0, the active plane-2 word in phase 1, the bitwise inverse of plane 1 in phase 2 and the bitwise inverse of plane 2 in phase 3.
- R6: Between successive driven phases, com_o changes by flipping bits 1:0 (mask 3'b011) or bit 2 (mask 3'b100), and the two masks alternate.
- R7: While en_i is high, com_o and seg_o change only on the clock edge that samples tick_i high.
- R8: A word loaded with upd_i takes effect only at the tick that enters phase 0. Loads during a frame do not alter the phases that remain in that frame.
- R9: done_o pulses high for exactly one cycle, in the cycle where the newly loaded words first appear in phase 0. It stays low at phase-0 entries with nothing pending.
- R10: If upd_i coincides with the tick that enters phase 0, that phase shows the previously held words and the new words wait for the next frame. With several loads before a transfer, the last one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Drive enable; low forces all outputs low |
| tick_i | input | 1 | One-cycle phase-advance pulse |
| upd_i | input | 1 | Load strobe for the two plane words |
| plane1_i | input | SEG_W | Segment word for backplane 1 |
| plane2_i | input | SEG_W | Segment word for backplane 2 |
| com_o | output | 3 | Binary common-drive pins {top, middle, low} |
| seg_o | output | SEG_W | Segment line levels |
| done_o | output | 1 | Pulse marking the phase-0 data transfer |

## Verification
The bench sweeps many word patterns across full frames and places the load strobe at every phase offset. A design that copied data immediately would show mixed or unbalanced data in phases 1 to 3 of the current frame, and the bench catches that. The bench also lines a load up with the wrapping tick, where a design that gave priority to the new strobe would display the wrong frame or lose a word. It disables the driver in mid-frame and checks that the next enabled tick restarts at phase 0, not at the stalled phase. A faulty flip mask, which would produce an illegal common code, shows up in the per-phase common checks.

// File: rtl/lcd2bp_pkg.sv
package lcd2bp_pkg;
  localparam int unsigned COM_W = 3;

  typedef enum logic [1:0] {
    PH_D1 = 2'd0,
    PH_D2 = 2'd1,
    PH_N1 = 2'd2,
    PH_N2 = 2'd3
  } phase_e;

  // image of phase 3; the first flip lands on phase 0
  localparam logic [COM_W-1:0] COM_PARK = 3'b101;
  localparam logic [COM_W-1:0] FLIP_LO  = 3'b011;
  localparam logic [COM_W-1:0] FLIP_HI  = 3'b100;
endpackage

// File: rtl/lcd2bp_seq.sv
module lcd2bp_seq
  import lcd2bp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output phase_e           ph_nxt_o,
  output logic             step_o,
  output logic [COM_W-1:0] com_o
);
  phase_e           ph_q;
  logic [1:0]       ph_inc;
  logic [COM_W-1:0] img_q, flip_q, com_q, img_nxt;

  assign ph_inc   = ph_q + 2'd1;
  assign ph_nxt_o = phase_e'(ph_inc);
  assign step_o   = en_i & tick_i;
  assign img_nxt  = img_q ^ flip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_N2;
      img_q  <= COM_PARK;
      flip_q <= FLIP_HI;
      com_q  <= '0;
    end else if (!en_i) begin
      ph_q   <= PH_N2;
      img_q  <= COM_PARK;
      flip_q <= FLIP_HI;
      com_q  <= '0;
    end else if (tick_i) begin
      ph_q   <= ph_nxt_o;
      img_q  <= img_nxt;
      flip_q <= (flip_q == FLIP_HI) ? FLIP_LO : FLIP_HI;
      com_q  <= img_nxt;
    end
  end

  assign com_o = com_q;
endmodule

// File: rtl/lcd2bp_stage.sv
module lcd2bp_stage
  import lcd2bp_pkg::*;
#(
  parameter int unsigned SEG_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  phase_e           ph_nxt_i,
  input  logic             upd_i,
  input  logic [SEG_W-1:0] plane1_i,
  input  logic [SEG_W-1:0] plane2_i,
  output logic [SEG_W-1:0] a1_nxt_o,
  output logic [SEG_W-1:0] a2_nxt_o,
  output logic             done_o
);
  logic [SEG_W-1:0] hold1_q, hold2_q, act1_q, act2_q;
  logic             pend_q, done_q, xfer;

  assign xfer     = step_i && (ph_nxt_i == PH_D1) && pend_q;
  assign a1_nxt_o = xfer ? hold1_q : act1_q;
  assign a2_nxt_o = xfer ? hold2_q : act2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold1_q <= '0;
      hold2_q <= '0;
      act1_q  <= '0;
      act2_q  <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      act1_q <= a1_nxt_o;
      act2_q <= a2_nxt_o;
      done_q <= xfer;
      // a fresh load wins over the clear of the word being transferred
      if (upd_i) begin
        hold1_q <= plane1_i;
        hold2_q <= plane2_i;
        pend_q  <= 1'b1;
      end else if (xfer) begin
        pend_q  <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/lcd2bp_segmux.sv
module lcd2bp_segmux
  import lcd2bp_pkg::*;
#(
  parameter int unsigned SEG_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  phase_e           ph_nxt_i,
  input  logic [SEG_W-1:0] a1_i,
  input  logic [SEG_W-1:0] a2_i,
  output logic [SEG_W-1:0] seg_o
);
  logic             sel2, inv;
  logic [SEG_W-1:0] pick, seg_q;

  assign sel2 = ph_nxt_i[0];
  assign inv  = ph_nxt_i[1];

  for (genvar b = 0; b < SEG_W; b++) begin : g_bit
    assign pick[b] = (sel2 ? a2_i[b] : a1_i[b]) ^ inv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seg_q <= '0;
    else if (!en_i)   seg_q <= '0;
    else if (step_i)  seg_q <= pick;
  end

  assign seg_o = seg_q;
endmodule

// File: rtl/lcd2bp_drv.sv
module lcd2bp_drv
  import lcd2bp_pkg::*;
#(
  parameter int unsigned SEG_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             upd_i,
  input  logic [SEG_W-1:0] plane1_i,
  input  logic [SEG_W-1:0] plane2_i,
  output logic [COM_W-1:0] com_o,
  output logic [SEG_W-1:0] seg_o,
  output logic             done_o
);
  phase_e           ph_nxt;
  logic             step;
  logic [SEG_W-1:0] a1_nxt, a2_nxt;

  lcd2bp_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_i),
    .ph_nxt_o (ph_nxt),
    .step_o   (step),
    .com_o    (com_o)
  );

  lcd2bp_stage #(.SEG_W(SEG_W)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .ph_nxt_i (ph_nxt),
    .upd_i    (upd_i),
    .plane1_i (plane1_i),
    .plane2_i (plane2_i),
    .a1_nxt_o (a1_nxt),
    .a2_nxt_o (a2_nxt),
    .done_o   (done_o)
  );

  lcd2bp_segmux #(.SEG_W(SEG_W)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .step_i   (step),
    .ph_nxt_i (ph_nxt),
    .a1_i     (a1_nxt),
    .a2_i     (a2_nxt),
    .seg_o    (seg_o)
  );
endmodule

// File: rtl/lcd2bp_chk.sv
module lcd2bp_chk #(
  parameter int unsigned SEG_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             tick_i,
  input logic [2:0]       com_o,
  input logic [SEG_W-1:0] seg_o,
  input logic             done_o
);
  // R2
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (com_o == 3'b000) && (seg_o == '0));

  // R3
  first_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && (com_o == 3'b000) |=> com_o == 3'b001);

  // R4
  legal_com_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_o != 3'b011 && com_o != 3'b100 && com_o != 3'b111);

  // R6
  flip_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && (com_o != 3'b000) |=>
      ((com_o ^ $past(com_o)) == 3'b011) || ((com_o ^ $past(com_o)) == 3'b100));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i |=> $stable(com_o) && $stable(seg_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> com_o == 3'b001);
endmodule

bind lcd2bp_drv lcd2bp_chk #(.SEG_W(SEG_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .tick_i (tick_i),
  .com_o  (com_o),
  .seg_o  (seg_o),
  .done_o (done_o)
);

// File: tb/lcd2bp_drv_test.sv
`timescale 1ns/1ps
module lcd2bp_drv_test;
  localparam int SW = 13;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en = 1'b0, tick = 1'b0, upd = 1'b0;
  logic [SW-1:0] p1 = '0, p2 = '0;
  logic [2:0]    com;
  logic [SW-1:0] seg;
  logic          done;

  int n_chk = 0, n_fail = 0;

  int            m_ph = -1;
  logic [SW-1:0] m_a1 = '0, m_a2 = '0, m_h1 = '0, m_h2 = '0;
  bit            m_pend = 1'b0, m_done = 1'b0;

  always #2.5 clk = ~clk;

  lcd2bp_drv #(.SEG_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .tick_i(tick), .upd_i(upd),
    .plane1_i(p1), .plane2_i(p2), .com_o(com), .seg_o(seg), .done_o(done)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_com(input int p);
    logic hi, mid;
    if (p < 0) return 3'b000;
    hi  = p[1];
    mid = p[1] ^ p[0];
    return {hi, mid, ~mid};
  endfunction

  function automatic logic [SW-1:0] exp_seg(input int p);
    if (p < 0) return '0;
    return (p[0] ? m_a2 : m_a1) ^ {SW{p[1]}};
  endfunction

  task automatic check_all(input string tag);
    chk(32'(com), 32'(exp_com(m_ph)), tag, "com");
    chk(32'(seg), 32'(exp_seg(m_ph)), tag, "seg");
    chk(32'(done), 32'(m_done), tag, "done");
  endtask

  task automatic cyc(input bit tk, input bit up, input logic [SW-1:0] v1,
                     input logic [SW-1:0] v2, input string tag);
    @(negedge clk);
    tick = tk; upd = up; p1 = v1; p2 = v2;
    @(posedge clk);
    m_done = 1'b0;
    if (!en) m_ph = -1;
    else if (tk) begin
      m_ph = (m_ph < 0) ? 0 : (m_ph + 1) % 4;
      if (m_ph == 0 && m_pend) begin
        m_a1 = m_h1; m_a2 = m_h2; m_pend = 1'b0; m_done = 1'b1;
      end
    end
    if (up) begin
      m_h1 = v1; m_h2 = v2; m_pend = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0; upd = 1'b0;
    check_all(tag);
  endtask

  task automatic set_en(input bit v, input string tag);
    @(negedge clk);
    en = v;
    @(posedge clk);
    m_done = 1'b0;
    if (!v) m_ph = -1;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_ni = 1'b1;

    // disabled: ticks ignored, load pends
    cyc(1'b0, 1'b0, '0, '0, "R2");
    cyc(1'b1, 1'b0, '0, '0, "R2");
    cyc(1'b0, 1'b1, 13'h0A5C, 13'h1133, "R2");
    cyc(1'b1, 1'b0, '0, '0, "R2");
    set_en(1'b1, "R3");
    cyc(1'b0, 1'b0, '0, '0, "R7");
    cyc(1'b1, 1'b0, '0, '0, "R3/R9");
    cyc(1'b0, 1'b0, '0, '0, "R9");

    // sweep patterns with the load at every phase offset
    for (int k = 0; k < 24; k++) begin
      logic [SW-1:0] v1, v2;
      v1 = SW'((32'h1 << (k % SW)) ^ (k * 32'h1F3));
      v2 = ~v1 ^ SW'(k << 3);
      for (int s = 0; s < 4; s++) begin
        cyc(1'b1, (s == (k % 4)), v1, v2, "R4/R5/R8/R9");
        cyc(1'b0, 1'b0, '0, '0, "R7");
      end
    end

    // load coinciding with the wrapping tick
    while (m_ph != 3) cyc(1'b1, 1'b0, '0, '0, "R4");
    cyc(1'b0, 1'b1, 13'h1F0F, 13'h00FF, "R8");
    cyc(1'b1, 1'b1, 13'h0123, 13'h1ABC, "R10");
    for (int s = 0; s < 4; s++) cyc(1'b1, 1'b0, '0, '0, "R10");

    // several loads before one transfer: last wins
    cyc(1'b0, 1'b1, 13'h0001, 13'h0002, "R10");
    cyc(1'b0, 1'b1, 13'h1555, 13'h0AAA, "R10");
    for (int s = 0; s < 5; s++) cyc(1'b1, 1'b0, '0, '0, "R10");

    // phase-0 entries with nothing pending
    for (int s = 0; s < 4; s++) cyc(1'b1, 1'b0, '0, '0, "R9");

    // disable mid-frame, restart at phase 0
    while (m_ph != 1) cyc(1'b1, 1'b0, '0, '0, "R4");
    set_en(1'b0, "R2");
    cyc(1'b1, 1'b0, '0, '0, "R2");
    cyc(1'b1, 1'b1, 13'h0F0F, 13'h10F0, "R2");
    set_en(1'b1, "R7");
    cyc(1'b0, 1'b0, '0, '0, "R7");
    cyc(1'b1, 1'b0, '0, '0, "R3");
    for (int s = 0; s < 6; s++) cyc(1'b1, 1'b0, '0, '0, "R4/R6");

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule